// File: doc/BRIEF.md
# Programmable Timeout Watchdog Timer

A watchdog timer for a chip's register space. Software picks a timeout index and then sets an enable bit. From that moment a down-counter runs, and it reloads only when software writes a fixed key word to the restart register. If software stops servicing the timer and the counter reaches zero, the block drives a reset request for a fixed number of cycles. It then reloads and keeps counting.

The enable is sticky: once set, nothing that software writes can clear it. Only the block's own reset input stops the timer. The timeout period is a power of two, `2^(BASE_EXP+index)` cycles. `BASE_EXP` is 16 by default and the index runs from 0 to 15. A second index field is used only for the first load after the enable, so a system can give a long boot window and then a short running window.

Registers are reached over a plain bus with no handshake: address, write strobe, write data, and read data that is returned one cycle after the address is presented.

Top module: `wdt_timer`

## Requirements
- R1: After `rst_n` is released, the enable is 0, both index fields are 0, the count reads all ones (`2^(BASE_EXP+15)-1`) and does not change, `wdt_rst` is low and `rdata` is 0.
- R2: Register map with byte offsets. 0x00 holds the enable in bit 0. 0x04 holds the running index in bits [3:0] and the first-load index in bits [7:4]. 0x08 reads the count, zero-extended. 0x0C and every unmapped address read 0. `rdata` reflects the address sampled at the previous clock edge.
- R3: Writing 1 to bit 0 at 0x00 while the timer is disabled sets the enable. It loads the count with `2^(BASE_EXP+first-load index)-1`.
- R4: Once set, the enable stays set. Writing 0 to bit 0 at 0x00 leaves the enable and the count unaffected.
- R5: While the timer is enabled and the count is non-zero, the count drops by one each cycle.
- R6: While the timer is enabled, writing the full word 0x00000076 to 0x0C loads the count with `2^(BASE_EXP+running index)-1`.
- R7: Writing any other value to 0x0C leaves the count on its normal decrement path.
- R8: A write to 0x04 always updates both index fields. If the timer is enabled, the same write also reloads the count from the newly written running index.
- R9: When the timer is enabled and the count is 0, and no reload write occurs in that cycle, `wdt_rst` goes high from the next cycle for exactly `RST_LEN` cycles. In that same next cycle the count reloads from the running index, so later pulses follow every `2^(BASE_EXP+running index)` cycles.
- R10: While the timer is disabled, writes to 0x0C and 0x04 do not change the count.
- R11: Asserting `rst_n` while the timer runs stops it. The block returns to the R1 state and any reset pulse in progress ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| addr | input | AW | Byte address of the register access |
| we | input | 1 | Write strobe, one cycle per write |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the address of the previous cycle |
| wdt_rst | output | 1 | Reset request, high for RST_LEN cycles after expiry |

## Verification
The assertions assume that the bus inputs are free of X whenever `rst_n` is high. They also assume that `we` is a single-cycle strobe whose address and data are valid in the same cycle. The bench drives every bus input from its own tasks on the falling edge, and it returns `we` to 0 after each write, so no write is ever half-formed. The bench uses `BASE_EXP` of 4 and `RST_LEN` of 8. This makes the shortest period (16 cycles) longer than the pulse, so the assertions never see a pulse that restarts itself. It also keeps the full sweep of all sixteen indices within a short run.

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int BASE_EXP = 16,
  parameter int RST_LEN  = 8,
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter logic [31:0] KEY = 32'h0000_0076
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          wdt_rst
);
  localparam int CW  = BASE_EXP + 15;
  localparam int PLW = $clog2(RST_LEN + 1);
  localparam logic [AW-1:0] OFF_CTRL  = AW'(8'h00);
  localparam logic [AW-1:0] OFF_RANGE = AW'(8'h04);
  localparam logic [AW-1:0] OFF_COUNT = AW'(8'h08);
  localparam logic [AW-1:0] OFF_KICK  = AW'(8'h0C);

  logic           en;
  logic [3:0]     top, top_first;
  logic [CW-1:0]  count;
  logic [PLW-1:0] pulse;

  function automatic logic [CW-1:0] load_of(input logic [3:0] idx);
    logic [CW:0] span;
    span = ({{CW{1'b0}}, 1'b1} << (BASE_EXP + int'(idx))) - 1'b1;
    return span[CW-1:0];
  endfunction

  wire wr_ctrl  = we && (addr == OFF_CTRL);
  wire wr_range = we && (addr == OFF_RANGE);
  wire wr_kick  = we && (addr == OFF_KICK);

  wire en_set   = wr_ctrl && wdata[0] && !en;
  wire kick     = en && wr_kick && (32'(wdata) == KEY);
  wire restart  = en && wr_range;
  wire expire   = en && (count == '0) && !kick && !restart;

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      OFF_CTRL:  rd_mux = DW'(en);
      OFF_RANGE: rd_mux = DW'({top_first, top});
      OFF_COUNT: rd_mux = DW'(count);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      top       <= '0;
      top_first <= '0;
      count     <= '1;
      pulse     <= '0;
      rdata     <= '0;
    end else begin
      rdata <= rd_mux;
      if (en_set) en <= 1'b1;
      if (wr_range) {top_first, top} <= wdata[7:0];

      if (en_set)               count <= load_of(top_first);
      else if (restart)         count <= load_of(wdata[3:0]);
      else if (kick || expire)  count <= load_of(top);
      else if (en)              count <= count - 1'b1;

      if (expire)               pulse <= PLW'(RST_LEN);
      else if (pulse != '0)     pulse <= pulse - 1'b1;
    end
  end

  assign wdt_rst = (pulse != '0);
endmodule

module wdt_timer_chk #(
  parameter int BASE_EXP = 16,
  parameter int RST_LEN  = 8,
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter logic [31:0] KEY = 32'h0000_0076
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [AW-1:0]        addr,
  input logic                 we,
  input logic [DW-1:0]        wdata,
  input logic                 wdt_rst,
  input logic                 en,
  input logic [BASE_EXP+14:0] count
);
  wire reload_wr = we && ((addr == AW'(8'h04)) ||
                          ((addr == AW'(8'h0C)) && (32'(wdata) == KEY)));
  wire en_wr     = we && (addr == AW'(8'h00)) && wdata[0];
  int  hi_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_run <= 0;
    else        hi_run <= wdt_rst ? hi_run + 1 : 0;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en); // R4
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !en_wr) |=> $stable(count)); // R10
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count != '0 && !we) |=> (count == $past(count) - 1'b1)); // R5
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count != '0 && we && addr == AW'(8'h0C) && 32'(wdata) != KEY)
      |=> (count == $past(count) - 1'b1)); // R7
  AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count == '0 && !reload_wr) |=> wdt_rst); // R9
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= RST_LEN); // R9
  AST_NO_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !wdt_rst); // R1
endmodule

bind wdt_timer wdt_timer_chk #(
  .BASE_EXP(BASE_EXP), .RST_LEN(RST_LEN), .AW(AW), .DW(DW), .KEY(KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
  .wdt_rst(wdt_rst), .en(en), .count(count)
);

// File: tb/sim_wdt_timer.sv
`timescale 1ns/1ps
module sim_wdt_timer;
  localparam int B  = 4;
  localparam int RL = 8;
  localparam logic [31:0] MAXC = (32'd1 << (B + 15)) - 1;

  logic        clk = 0, rst_n = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        wdt_rst;
  int errs = 0, total = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_timer #(.BASE_EXP(B), .RST_LEN(RL), .AW(8), .DW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .wdt_rst(wdt_rst));

  function automatic logic [31:0] ld(input int idx);
    return (32'd1 << (B + idx)) - 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1; wdata = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; we = 0;
    @(posedge clk); #1; v = rdata;
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 rdata", rdata, 0);
    check("R1 wdt_rst", {31'd0, wdt_rst}, 0);
    rd(8'h00, v); check("R1 enable", v, 0);
    rd(8'h04, v); check("R1 range", v, 0);
    rd(8'h08, v); check("R1 count", v, MAXC);
    edges(5);
    rd(8'h08, v); check("R1 count frozen", v, MAXC);
    rd(8'h0C, v); check("R2 kick reads 0", v, 0);
    rd(8'h10, v); check("R2 unmapped", v, 0);
    rd(8'hFC, v); check("R2 unmapped high", v, 0);

    wr(8'h0C, 32'h76);
    rd(8'h08, v); check("R10 kick while off", v, MAXC);
    wr(8'h04, 32'h12);
    rd(8'h08, v); check("R10 range while off", v, MAXC);
    rd(8'h04, v); check("R8 range stored", v, 32'h12);

    wr(8'h00, 32'h1);
    rd(8'h08, v); check("R3 first load", v, ld(1));
    rd(8'h08, v); check("R5 decrement", v, ld(1) - 1);
    rd(8'h08, v); check("R5 decrement 2", v, ld(1) - 2);
    rd(8'h00, v); check("R3 enable set", v, 1);
    wr(8'h00, 32'h0);
    rd(8'h00, v); check("R4 sticky", v, 1);

    wr(8'h0C, 32'h76);
    rd(8'h08, v); check("R6 kick load", v, ld(2));
    wr(8'h0C, 32'h75);
    rd(8'h08, v); check("R7 bad key", v, ld(2) - 2);
    wr(8'h0C, 32'h176);
    rd(8'h08, v); check("R7 bad upper bits", v, ld(2) - 4);

    for (int i = 0; i < 16; i++) begin
      wr(8'h04, 32'(i) | 32'h50);
      rd(8'h08, v); check("R8 restart sweep", v, ld(i));
      rd(8'h04, v); check("R8 range sweep", v, 32'(i) | 32'h50);
    end

    for (int i = 0; i < 4; i++) begin
      int p;
      p = 1 << (B + i);
      wr(8'h04, 32'(i));
      edges(p - 1);
      check("R9 no early pulse", {31'd0, wdt_rst}, 0);
      edges(1);
      check("R9 pulse start", {31'd0, wdt_rst}, 1);
      edges(RL - 1);
      check("R9 pulse held", {31'd0, wdt_rst}, 1);
      edges(1);
      check("R9 pulse end", {31'd0, wdt_rst}, 0);
      edges(p - RL - 1);
      check("R9 quiet before repeat", {31'd0, wdt_rst}, 0);
      edges(1);
      check("R9 repeat pulse", {31'd0, wdt_rst}, 1);
    end

    edges(2);
    @(negedge clk) rst_n = 0;
    @(posedge clk); #1;
    check("R11 pulse cleared", {31'd0, wdt_rst}, 0);
    @(negedge clk) rst_n = 1;
    rd(8'h00, v); check("R11 enable cleared", v, 0);
    rd(8'h08, v); check("R11 count max", v, MAXC);
    edges(40);
    check("R11 stays quiet", {31'd0, wdt_rst}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule